// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block decides whether the receive line has lost its signal. The analog front end supplies one indication for each received bit interval. The indication says whether that interval carried a mark above the amplitude threshold. The monitor declares loss of signal after a long enough run of intervals with no such mark. It releases the loss state only after a whole observation window in which marks come back with enough density and with no zero run that is too long. A mode input picks one of two criteria sets, a short one for E1 lines and a long one for T1/J1 lines.

Every change of the loss state can raise a sticky interrupt flag. Software chooses whether only the entry into loss raises the flag, or whether both entry and exit raise it. An enable gates the flag onto an active-high, level interrupt output. A write-one-to-clear pulse resets the flag. While loss is present and insertion is switched on, the monitor forces every received data bit to one.

Top module: `los_monitor`

## Requirements
- R1: With cfg_e1_mode=1, los_status rises when the 32nd consecutive valid interval without a mark is sampled. A mark anywhere in the run restarts the count, so 31 no-mark intervals leave los_status at 0.
- R2: With cfg_e1_mode=0 (T1), los_status rises when the 175th consecutive valid interval without a mark is sampled. 174 such intervals leave it at 0.
- R3: In E1 mode, a 32-interval window opens on the first valid interval after loss is declared, and each new window follows the previous one directly. At the last interval of a window, los_status falls only if the window held at least 4 marks and no run of more than 15 no-mark intervals, counted from the window start. Otherwise a new window begins.
- R4: In T1 mode the window is 175 intervals long. It needs at least 22 marks (12.5 percent, rounded up) and no no-mark run of more than 99 intervals.
- R5: Cycles with bit_valid=0 have no effect on any count, whatever mark_ok is.
- R6: los_status changes at the clock edge that samples the deciding interval.
- R7: With cfg_any_edge=0, only a 0-to-1 change of los_status sets int_sticky. With cfg_any_edge=1, a change in either direction sets it.
- R8: A clr_sticky pulse clears int_sticky on the next edge. A status change in the same cycle wins, and the flag stays 1.
- R9: irq is 1 exactly while int_sticky=1 and cfg_int_en=1.
- R10: While los_status=1 and cfg_insert_ones=1, rx_data_out is 1. Otherwise rx_data_out equals rx_data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe for one received bit interval |
| mark_ok | input | 1 | The interval held a mark above the threshold |
| rx_data_in | input | 1 | Received data bit |
| cfg_e1_mode | input | 1 | 1 selects the E1 criteria, 0 selects the T1/J1 criteria |
| cfg_any_edge | input | 1 | 1 means any status change sets the flag, 0 means only a rise does |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_insert_ones | input | 1 | Force ones into the data during loss |
| clr_sticky | input | 1 | Write-one-to-clear pulse for the flag |
| los_status | output | 1 | Current loss state |
| int_sticky | output | 1 | Sticky event flag |
| irq | output | 1 | Level interrupt, active high |
| rx_data_out | output | 1 | Received data after insertion |

## Verification
los_status and int_sticky are registered. Both settle one edge after the deciding interval or the clear pulse is sampled. irq and rx_data_out follow their inputs within the same cycle. The bench drives each interval at a falling edge and holds it through exactly one rising edge. It then reads the outputs at the next falling edge, so every expected value is due at the point where it is sampled. The boundary checks fall on the interval just before a threshold and on the threshold interval itself.

// File: rtl/los_pkg.sv
package los_pkg;
    typedef struct packed {
        logic los;
        logic sticky;
    } los_state_t;

    function automatic logic status_event(input logic cur, input logic nxt, input logic any_edge);
        return any_edge ? (cur != nxt) : (!cur && nxt);
    endfunction
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          mark,
    input  logic          los_q,
    input  logic [CW-1:0] limit,
    output logic          declare
);
    logic [CW-1:0] run_d, run_q;
    logic [CW-1:0] run_inc;

    always_comb begin
        run_inc = (run_q == {CW{1'b1}}) ? run_q : run_q + CW'(1);
        run_d   = run_q;
        declare = 1'b0;
        if (los_q) begin
            run_d = '0;
        end else if (bit_valid) begin
            if (mark) begin
                run_d = '0;
            end else begin
                run_d = run_inc;
                if (run_inc >= limit) begin
                    declare = 1'b1;
                    run_d   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/los_clear_win.sv
module los_clear_win #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          mark,
    input  logic          los_q,
    input  logic [CW-1:0] win_len,
    input  logic [CW-1:0] min_marks,
    input  logic [CW-1:0] max_zrun,
    output logic          clear
);
    typedef struct packed {
        logic [CW-1:0] pos;
        logic [CW-1:0] marks;
        logic [CW-1:0] zrun;
        logic          bad;
    } win_t;

    win_t w_d, w_q;
    win_t step;

    always_comb begin
        step       = w_q;
        step.pos   = w_q.pos + CW'(1);
        step.marks = w_q.marks + CW'(mark);
        step.zrun  = mark ? '0 : w_q.zrun + CW'(1);
        step.bad   = w_q.bad | (step.zrun > max_zrun);

        w_d   = w_q;
        clear = 1'b0;
        if (!los_q) begin
            w_d = '0;
        end else if (bit_valid) begin
            w_d = step;
            if (step.pos >= win_len) begin
                clear = !step.bad && (step.marks >= min_marks);
                w_d   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end
endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int E1_DECL   = 32,
    parameter int E1_WIN    = 32,
    parameter int E1_MARKS  = 4,
    parameter int E1_MAXZ   = 15,
    parameter int T1_DECL   = 175,
    parameter int T1_WIN    = 175,
    parameter int T1_MARKS  = 22,
    parameter int T1_MAXZ   = 99
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic mark_ok,
    input  logic rx_data_in,
    input  logic cfg_e1_mode,
    input  logic cfg_any_edge,
    input  logic cfg_int_en,
    input  logic cfg_insert_ones,
    input  logic clr_sticky,
    output logic los_status,
    output logic int_sticky,
    output logic irq,
    output logic rx_data_out
);
    localparam int LIM_A   = (E1_DECL > E1_WIN) ? E1_DECL : E1_WIN;
    localparam int LIM_B   = (T1_DECL > T1_WIN) ? T1_DECL : T1_WIN;
    localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int CW      = $clog2(LIM_MAX + 2);

    los_state_t st_d, st_q;
    logic [CW-1:0] decl_lim, win_lim, mark_lim, zrun_lim;
    logic          declare, clear;

    always_comb begin
        if (cfg_e1_mode) begin
            decl_lim = CW'(E1_DECL);
            win_lim  = CW'(E1_WIN);
            mark_lim = CW'(E1_MARKS);
            zrun_lim = CW'(E1_MAXZ);
        end else begin
            decl_lim = CW'(T1_DECL);
            win_lim  = CW'(T1_WIN);
            mark_lim = CW'(T1_MARKS);
            zrun_lim = CW'(T1_MAXZ);
        end
    end

    los_zero_run #(.CW(CW)) u_decl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .mark      (mark_ok),
        .los_q     (st_q.los),
        .limit     (decl_lim),
        .declare   (declare)
    );

    los_clear_win #(.CW(CW)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .mark      (mark_ok),
        .los_q     (st_q.los),
        .win_len   (win_lim),
        .min_marks (mark_lim),
        .max_zrun  (zrun_lim),
        .clear     (clear)
    );

    always_comb begin
        st_d = st_q;
        if (declare)    st_d.los = 1'b1;
        else if (clear) st_d.los = 1'b0;

        if (status_event(st_q.los, st_d.los, cfg_any_edge)) st_d.sticky = 1'b1;
        else if (clr_sticky)                                 st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign los_status  = st_q.los;
    assign int_sticky  = st_q.sticky;
    assign irq         = st_q.sticky & cfg_int_en;
    assign rx_data_out = rx_data_in | (st_q.los & cfg_insert_ones);
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic mark_ok,
    input logic rx_data_in,
    input logic cfg_any_edge,
    input logic cfg_int_en,
    input logic cfg_insert_ones,
    input logic clr_sticky,
    input logic los_status,
    input logic int_sticky,
    input logic irq,
    input logic rx_data_out
);
    // R1/R2: entry into loss only on a sampled no-mark interval
    p_rise_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_status) |-> $past(bit_valid && !mark_ok));

    // R5: idle cycles never change the loss state
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_valid) |-> $stable(los_status));

    // R7: entering loss always raises the flag
    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_status) |-> int_sticky);

    // R7: leaving loss raises the flag when any edge is selected
    p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(los_status) && $past(cfg_any_edge)) |-> int_sticky);

    // R8: the flag drops only after a clear pulse
    p_w1c_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_sticky) |-> $past(clr_sticky));

    // R9: the interrupt never fires without the enable
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_sticky && cfg_int_en));

    // R10: insertion forces ones
    always_comb begin
        if (rst_n && los_status && cfg_insert_ones)
            p_insert_r10: assert (rx_data_out);
        if (rst_n && !los_status)
            p_pass_r10: assert (rx_data_out == rx_data_in);
    end
endmodule

bind los_monitor los_monitor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bit_valid       (bit_valid),
    .mark_ok         (mark_ok),
    .rx_data_in      (rx_data_in),
    .cfg_any_edge    (cfg_any_edge),
    .cfg_int_en      (cfg_int_en),
    .cfg_insert_ones (cfg_insert_ones),
    .clr_sticky      (clr_sticky),
    .los_status      (los_status),
    .int_sticky      (int_sticky),
    .irq             (irq),
    .rx_data_out     (rx_data_out)
);

// File: tb/los_monitor_test.sv
`timescale 1ns/1ps
module los_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 0, mark_ok = 0, rx_data_in = 0;
    logic cfg_e1_mode = 1, cfg_any_edge = 0, cfg_int_en = 1, cfg_insert_ones = 0, clr_sticky = 0;
    logic los_status, int_sticky, irq, rx_data_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    los_monitor uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .mark_ok(mark_ok),
        .rx_data_in(rx_data_in), .cfg_e1_mode(cfg_e1_mode), .cfg_any_edge(cfg_any_edge),
        .cfg_int_en(cfg_int_en), .cfg_insert_ones(cfg_insert_ones), .clr_sticky(clr_sticky),
        .los_status(los_status), .int_sticky(int_sticky), .irq(irq), .rx_data_out(rx_data_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic m, input logic clr = 1'b0);
        @(negedge clk);
        bit_valid = 1'b1; mark_ok = m; clr_sticky = clr;
        @(negedge clk);
        bit_valid = 1'b0; mark_ok = 1'b0; clr_sticky = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_sticky = 1'b1;
        @(negedge clk); clr_sticky = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset los", los_status, 1'b0);
        chk("R8 reset sticky", int_sticky, 1'b0);
        chk("R9 reset irq", irq, 1'b0);
        rx_data_in = 1'b0; #0.1;
        chk("R10 pass-through", rx_data_out, 1'b0);
    endtask

    task automatic t_e1_declare();
        cfg_e1_mode = 1;
        send_zeros(20); send_bit(1'b1); send_zeros(31);
        chk("R1 run restarted by mark", los_status, 1'b0);
        // R5: idle cycles with mark_ok high are ignored
        @(negedge clk); mark_ok = 1'b1;
        repeat (10) @(negedge clk);
        mark_ok = 1'b0;
        chk("R5 idle ignored", los_status, 1'b0);
        send_bit(1'b0);
        chk("R1 declared at 32nd zero", los_status, 1'b1);
        chk("R7 rise sets sticky", int_sticky, 1'b1);
        chk("R9 irq enabled", irq, 1'b1);
        @(negedge clk); cfg_int_en = 0; #0.1;
        chk("R9 irq masked", irq, 1'b0);
        cfg_int_en = 1;
    endtask

    task automatic t_insert();
        @(negedge clk); rx_data_in = 0; cfg_insert_ones = 1; #0.1;
        chk("R10 ones inserted", rx_data_out, 1'b1);
        cfg_insert_ones = 0; #0.1;
        chk("R10 insert off", rx_data_out, 1'b0);
    endtask

    task automatic e1_good_window(input string tag);
        for (int k = 0; k < 3; k++) begin send_zeros(7); send_bit(1'b1); end
        send_zeros(7);
        chk({tag, " held before window end"}, los_status, 1'b1);
        send_bit(1'b1);
        chk({tag, " cleared at window end"}, los_status, 1'b0);
    endtask

    task automatic t_e1_clear();
        // LOS active from t_e1_declare; sticky cleared first (R8)
        pulse_clr();
        chk("R8 w1c clears sticky", int_sticky, 1'b0);
        for (int k = 0; k < 3; k++) begin send_zeros(7); send_bit(1'b1); end
        send_zeros(8);
        chk("R3 3 marks not enough", los_status, 1'b1);
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        send_zeros(28);
        chk("R3 long zero run fails", los_status, 1'b1);
        cfg_any_edge = 0;
        e1_good_window("R3");
        chk("R7 fall ignored in rise mode", int_sticky, 1'b0);
    endtask

    task automatic t_edge_priority();
        cfg_any_edge = 1;
        send_zeros(31);
        send_bit(1'b0, 1'b1);
        chk("R1 declared again", los_status, 1'b1);
        chk("R8 event beats clear", int_sticky, 1'b1);
        pulse_clr();
        chk("R8 w1c", int_sticky, 1'b0);
        e1_good_window("R6");
        chk("R7 fall sets in any-edge mode", int_sticky, 1'b1);
        cfg_any_edge = 0;
        pulse_clr();
    endtask

    task automatic t_t1();
        cfg_e1_mode = 0;
        send_zeros(174);
        chk("R2 174 zeros", los_status, 1'b0);
        send_bit(1'b0);
        chk("R2 declared at 175th", los_status, 1'b1);
        for (int k = 0; k < 22; k++) send_bit(1'b1);
        send_zeros(153);
        chk("R4 zero run over 99 fails", los_status, 1'b1);
        for (int k = 0; k < 21; k++) begin send_zeros(7); send_bit(1'b1); end
        send_zeros(7);
        chk("R4 21 marks not enough", los_status, 1'b1);
        for (int k = 0; k < 21; k++) begin send_bit(1'b1); send_zeros(7); end
        send_bit(1'b1); send_zeros(5);
        chk("R4 held before window end", los_status, 1'b1);
        send_bit(1'b0);
        chk("R4 cleared with 22 marks", los_status, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_e1_declare();
        t_insert();
        t_e1_clear();
        t_edge_priority();
        t_t1();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule